// File: doc/BRIEF.md
# Control-Flow Signature Monitor

A watchdog coprocessor that watches the instruction fetch stream of a processor running one program. The program is cut into blocks with a single entry and a single exit. Tooling outside this unit precomputes a reference signature for each block. A start marker opens a block and seeds a 16-bit cyclic-code compressor. Every valid instruction word inside the block is folded into that compressor. At the exit marker, the run-time signature is compared with the reference that comes with the marker.

The monitor raises sticky error causes for three things: a signature mismatch, markers that arrive out of order (an exit with no open block, or a start while a block is already open), and a block whose exit does not arrive within a parameterised number of cycles. It counts closed blocks. It also latches the block index at which the first error of any kind was seen, so the fault can be located after the fact.

Top module: `cflow_sig_monitor`

## Requirements
- R1: After reset, err_o is 0, err_cause_o is 0, err_idx_o is 0 and blk_cnt_o is 0.
- R2: The signature is seeded with 16'hFFFF at a start marker. Each valid word is absorbed one bit at a time, most significant bit first. For each bit, fb = sig[15] ^ bit, then sig = {sig[14:0],0} XOR (fb ? 16'h1021 : 0). A valid word in the start cycle is the block's first word. Words with the valid strobe low, or words that arrive while no block is open, have no effect on any output.
- R3: An exit marker while a block is open closes the block and increments blk_cnt_o by one, wrapping at its width. blk_cnt_o changes in no other cycle. If the block's signature, including a valid word in the exit cycle, equals ref_sig_i, no error is raised.
- R4: If the signature at a valid exit differs from ref_sig_i, err_cause_o[0] (mismatch) is set.
- R5: An exit marker with no open block sets err_cause_o[1] (sequencing) and leaves blk_cnt_o unchanged.
- R6: A start marker while a block is open, without an exit in the same cycle, sets err_cause_o[1]. A new block then opens from the seed.
- R7: When exit and start coincide while a block is open, the exit closes the old block with its stored signature, without the word of that cycle. The start opens a new block whose first word is the word of that cycle. No sequencing error is raised.
- R8: A block may take its exit at the latest MAX_CYC cycles after its start cycle. If the exit has not arrived by then, err_cause_o[2] (timeout) is set at that cycle and the block is abandoned. A later exit marker is then a sequencing error.
- R9: err_cause_o bits are sticky until reset, and err_o is their OR. err_idx_o takes the value blk_cnt_o had in the cycle of the first error and holds it until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word valid strobe |
| instr_word_i | input | INSTR_W | Fetched instruction word |
| blk_start_i | input | 1 | Block entry marker |
| blk_end_i | input | 1 | Block exit marker |
| ref_sig_i | input | 16 | Reference signature for the closing block, valid with blk_end_i |
| err_o | output | 1 | Any error seen since reset |
| err_cause_o | output | 3 | Sticky causes: [0] mismatch, [1] sequencing, [2] timeout |
| err_idx_o | output | CNT_W | Block index at the first error |
| blk_cnt_o | output | CNT_W | Number of blocks closed by an exit marker |

## Verification
The assertions check on every cycle that the cause bits never clear, that the first-error index stays frozen, and that the block count moves only on an exit and only by one. They also check that an orphan exit or a nested start leads to a sequencing cause, and that a block reaching its age limit is abandoned with a timeout cause. The signature arithmetic cannot be shown by any property; only the bench scenarios show it. These scenarios sweep block lengths and valid-strobe gaps, flip each signature bit in turn, hit the age limit exactly and one cycle past it, and drive coinciding exit and start markers.

// File: rtl/cflow_sig_pkg.sv
package cflow_sig_pkg;
  localparam int SIG_W = 16;
  localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;
  localparam logic [SIG_W-1:0] SIG_SEED = 16'hFFFF;
  localparam int CAUSE_W = 3;

  typedef logic [SIG_W-1:0] sig_t;

  typedef struct packed {
    logic tmo;
    logic seq;
    logic mis;
  } err_cause_t;
endpackage

// File: rtl/cflow_sig_lfsr.sv
module cflow_sig_lfsr
  import cflow_sig_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               seed_i,
  input  logic               absorb_i,
  input  logic [INSTR_W-1:0] word_i,
  output sig_t               sig_o,
  output sig_t               fold_o
);
  function automatic sig_t fold(input sig_t s, input logic [INSTR_W-1:0] w);
    sig_t r;
    logic fb;
    r = s;
    for (int i = INSTR_W - 1; i >= 0; i--) begin
      fb = r[SIG_W-1] ^ w[i];
      r  = {r[SIG_W-2:0], 1'b0} ^ (fb ? SIG_POLY : '0);
    end
    return r;
  endfunction

  sig_t sig_q, base, fold_seed;

  assign fold_o    = fold(sig_q, word_i);
  assign fold_seed = fold(SIG_SEED, word_i);
  assign base      = seed_i ? SIG_SEED : sig_q;
  assign sig_o     = sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sig_q <= SIG_SEED;
    else if (absorb_i) sig_q <= seed_i ? fold_seed : fold_o;
    else               sig_q <= base;
  end
endmodule

// File: rtl/cflow_blk_seq.sv
module cflow_blk_seq #(
  parameter int MAX_CYC = 64,
  localparam int CYC_W = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             end_i,
  output logic             open_o,
  output logic [CYC_W-1:0] age_o,
  output logic             close_o,
  output logic             seq_err_o,
  output logic             tmo_o
);
  logic             open_q;
  logic [CYC_W-1:0] age_q;
  logic             stay;

  assign close_o   = end_i & open_q;
  assign seq_err_o = (end_i & ~open_q) | (start_i & open_q & ~end_i);
  assign tmo_o     = open_q & ~end_i & (age_q == CYC_W'(MAX_CYC - 1));
  assign stay      = open_q & ~end_i & ~tmo_o;
  assign open_o    = open_q;
  assign age_o     = age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      age_q  <= '0;
    end else begin
      open_q <= start_i | stay;
      if (start_i)   age_q <= '0;
      else if (stay) age_q <= age_q + CYC_W'(1);
    end
  end
endmodule

// File: rtl/cflow_err_log.sv
module cflow_err_log
  import cflow_sig_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             close_i,
  input  err_cause_t       hit_i,
  output err_cause_t       cause_o,
  output logic             err_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [CNT_W-1:0] cnt_o
);
  err_cause_t       cause_q;
  logic [CNT_W-1:0] idx_q, cnt_q;
  logic             first;

  assign first   = ~(|cause_q) & (|hit_i);
  assign cause_o = cause_q;
  assign err_o   = |cause_q;
  assign idx_o   = idx_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      cause_q <= cause_q | hit_i;
      if (first)   idx_q <= cnt_q;
      if (close_i) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cflow_sig_monitor.sv
module cflow_sig_monitor
  import cflow_sig_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int CNT_W   = 8,
  parameter int MAX_CYC = 64,
  localparam int CYC_W = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_word_i,
  input  logic               blk_start_i,
  input  logic               blk_end_i,
  input  logic [SIG_W-1:0]   ref_sig_i,
  output logic               err_o,
  output logic [CAUSE_W-1:0] err_cause_o,
  output logic [CNT_W-1:0]   err_idx_o,
  output logic [CNT_W-1:0]   blk_cnt_o
);
  logic             blk_open, blk_close, seq_err, tmo, absorb;
  logic [CYC_W-1:0] blk_age;
  sig_t             sig_q, sig_fold, end_sig;
  err_cause_t       hit, cause;

  cflow_blk_seq #(.MAX_CYC(MAX_CYC)) i_seq (
    .clk_i, .rst_ni,
    .start_i  (blk_start_i),
    .end_i    (blk_end_i),
    .open_o   (blk_open),
    .age_o    (blk_age),
    .close_o  (blk_close),
    .seq_err_o(seq_err),
    .tmo_o    (tmo)
  );

  // word belongs to the block that is open after this cycle's markers
  assign absorb = instr_valid_i & (blk_start_i | (blk_open & ~blk_end_i));

  cflow_sig_lfsr #(.INSTR_W(INSTR_W)) i_lfsr (
    .clk_i, .rst_ni,
    .seed_i  (blk_start_i),
    .absorb_i(absorb),
    .word_i  (instr_word_i),
    .sig_o   (sig_q),
    .fold_o  (sig_fold)
  );

  assign end_sig = (instr_valid_i & ~blk_start_i) ? sig_fold : sig_q;
  assign hit.mis = blk_close & (end_sig != ref_sig_i);
  assign hit.seq = seq_err;
  assign hit.tmo = tmo;

  cflow_err_log #(.CNT_W(CNT_W)) i_log (
    .clk_i, .rst_ni,
    .close_i(blk_close),
    .hit_i  (hit),
    .cause_o(cause),
    .err_o  (err_o),
    .idx_o  (err_idx_o),
    .cnt_o  (blk_cnt_o)
  );

  assign err_cause_o = cause;
endmodule

// File: rtl/cflow_sig_monitor_chk.sv
module cflow_sig_monitor_chk #(
  parameter int CNT_W   = 8,
  parameter int MAX_CYC = 64,
  parameter int CYC_W   = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blk_start_i,
  input logic             blk_end_i,
  input logic             blk_open,
  input logic [CYC_W-1:0] blk_age,
  input logic [2:0]       err_cause_o,
  input logic             err_o,
  input logic [CNT_W-1:0] err_idx_o,
  input logic [CNT_W-1:0] blk_cnt_o
);
  assert_cause_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((err_cause_o & $past(err_cause_o)) == $past(err_cause_o)));

  assert_idx_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(err_idx_o));

  assert_cnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_end_i |=> $stable(blk_cnt_o));

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_end_i && blk_open |=> blk_cnt_o == $past(blk_cnt_o) + CNT_W'(1));

  assert_orphan_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_end_i && !blk_open |=> err_cause_o[1] && $stable(blk_cnt_o));

  assert_nested_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_start_i && blk_open && !blk_end_i |=> err_cause_o[1] && blk_open);

  assert_age_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_open && !blk_end_i && !blk_start_i && blk_age == CYC_W'(MAX_CYC - 1)
      |=> err_cause_o[2] && !blk_open);
endmodule

bind cflow_sig_monitor cflow_sig_monitor_chk #(
  .CNT_W(CNT_W), .MAX_CYC(MAX_CYC), .CYC_W(CYC_W)
) i_chk (
  .clk_i, .rst_ni, .blk_start_i, .blk_end_i,
  .blk_open, .blk_age, .err_cause_o, .err_o, .err_idx_o, .blk_cnt_o
);

// File: tb/test_cflow_sig_monitor.sv
module test_cflow_sig_monitor;
  localparam int IW = 16;
  localparam int CW = 4;
  localparam int MC = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          instr_valid_i = 1'b0;
  logic [IW-1:0] instr_word_i = '0;
  logic          blk_start_i = 1'b0;
  logic          blk_end_i = 1'b0;
  logic [15:0]   ref_sig_i = '0;
  logic          err_o;
  logic [2:0]    err_cause_o;
  logic [CW-1:0] err_idx_o, blk_cnt_o;

  cflow_sig_monitor #(.INSTR_W(IW), .CNT_W(CW), .MAX_CYC(MC)) i_cflow_sig_monitor (
    .clk_i, .rst_ni, .instr_valid_i, .instr_word_i, .blk_start_i, .blk_end_i,
    .ref_sig_i, .err_o, .err_cause_o, .err_idx_o, .blk_cnt_o
  );

  always #4 clk_i = ~clk_i;

  int n_vec = 0, n_bad = 0;
  logic [31:0] lcg = 32'h1234_5678;

  // reference model state
  logic          m_open;
  logic [15:0]   m_sig;
  logic [CW-1:0] m_cnt, m_idx;
  logic [2:0]    m_cause;
  int            m_age;

  function automatic logic [15:0] crc(input logic [15:0] s, input logic [IW-1:0] w);
    logic [15:0] r = s;
    for (int i = IW - 1; i >= 0; i--) begin
      logic b = r[15] ^ w[i];
      r = {r[14:0], 1'b0};
      if (b) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [IW-1:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[31:16];
  endfunction

  function automatic logic [15:0] exp_end(input logic v, input logic [IW-1:0] w);
    return v ? crc(m_sig, w) : m_sig;
  endfunction

  task automatic check(input string tag);
    n_vec++;
    if (err_o !== (|m_cause) || err_cause_o !== m_cause ||
        err_idx_o !== m_idx || blk_cnt_o !== m_cnt) begin
      n_bad++;
      $display("FAIL %s: err=%b/%b cause=%b/%b idx=%0d/%0d cnt=%0d/%0d", tag,
               err_o, |m_cause, err_cause_o, m_cause, err_idx_o, m_idx, blk_cnt_o, m_cnt);
    end
  endtask

  task automatic cyc(input logic s, input logic e, input logic v,
                     input logic [IW-1:0] w, input logic [15:0] r, input string tag);
    logic seq, cls, tmo, mis;
    logic [15:0] es;
    blk_start_i = s; blk_end_i = e; instr_valid_i = v; instr_word_i = w; ref_sig_i = r;
    seq = (e && !m_open) || (s && m_open && !e);
    cls = e && m_open;
    tmo = m_open && !e && (m_age == MC - 1);
    es  = (v && !s) ? crc(m_sig, w) : m_sig;
    mis = cls && (es != r);
    if (m_cause == 0 && (seq || tmo || mis)) m_idx = m_cnt;
    m_cause = m_cause | {tmo, seq, mis};
    if (cls) m_cnt = m_cnt + 1'b1;
    if (s) begin
      m_sig = v ? crc(16'hFFFF, w) : 16'hFFFF;
      m_age = 0;
    end else if (m_open && !e && !tmo) begin
      if (v) m_sig = crc(m_sig, w);
      m_age++;
    end
    m_open = s || (m_open && !e && !tmo);
    @(negedge clk_i);
    blk_start_i = 0; blk_end_i = 0; instr_valid_i = 0;
    check(tag);
  endtask

  task automatic do_reset();
    rst_ni = 0;
    m_open = 0; m_sig = 16'hFFFF; m_cnt = 0; m_idx = 0; m_cause = 0; m_age = 0;
    @(negedge clk_i);
    check("R1");
    rst_ni = 1;
    @(negedge clk_i);
    check("R1");
  endtask

  // start with a word, len body cycles, exit; ref xored with flip
  task automatic run_block(input int len, input logic ev, input logic [15:0] flip,
                           input string tag);
    logic [IW-1:0] w;
    cyc(1, 0, 1, rnd(), 16'h0, tag);
    for (int k = 0; k < len; k++) cyc(0, 0, lcg[7], rnd(), 16'h0, tag);
    w = rnd();
    cyc(0, 1, ev, w, exp_end(ev, w) ^ flip, tag);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not end (expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    do_reset();

    // R2/R3: sweep block lengths and exit-cycle valid, with stray words between
    for (int len = 0; len < 11; len++) begin
      run_block(len, len[0], 16'h0, "R3");
      cyc(0, 0, 1, rnd(), 16'h0, "R2");
    end

    // R4/R9: every single-bit reference flip, after one good block
    for (int b = 0; b < 16; b++) begin
      do_reset();
      run_block(2, 1'b1, 16'h0, "R3");
      run_block(b % 5, b[0], 16'h1 << b, "R4");
      run_block(1, 1'b0, 16'h0, "R9");
    end

    // R5: orphan exit
    do_reset();
    cyc(0, 1, 1, rnd(), 16'hFFFF, "R5");
    run_block(3, 1'b1, 16'h0, "R5");

    // R6: nested start, then the new block closes cleanly
    do_reset();
    cyc(1, 0, 1, rnd(), 16'h0, "R6");
    cyc(0, 0, 1, rnd(), 16'h0, "R6");
    cyc(1, 0, 1, rnd(), 16'h0, "R6");
    cyc(0, 0, 1, rnd(), 16'h0, "R6");
    begin
      logic [IW-1:0] w = rnd();
      cyc(0, 1, 1, w, exp_end(1'b1, w), "R6");
    end

    // R7: exit and start coincide, back to back
    do_reset();
    cyc(1, 0, 1, rnd(), 16'h0, "R7");
    for (int k = 0; k < 6; k++) begin
      cyc(0, 0, 1, rnd(), 16'h0, "R7");
      cyc(1, 1, 1, rnd(), m_sig, "R7");
    end
    begin
      logic [IW-1:0] w = rnd();
      cyc(0, 1, 1, w, exp_end(1'b1, w), "R7");
    end

    // R8: exit exactly at the age limit, then one cycle late
    do_reset();
    cyc(1, 0, 1, rnd(), 16'h0, "R8");
    for (int k = 0; k < MC - 1; k++) cyc(0, 0, 1, rnd(), 16'h0, "R8");
    begin
      logic [IW-1:0] w = rnd();
      cyc(0, 1, 1, w, exp_end(1'b1, w), "R8");
    end
    cyc(1, 0, 1, rnd(), 16'h0, "R8");
    for (int k = 0; k < MC; k++) cyc(0, 0, 1, rnd(), 16'h0, "R8");
    cyc(0, 1, 0, rnd(), m_sig, "R8");
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, rnd(), 16'h0, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule